// File: doc/BRIEF.md
# DDR Write Burst Data Sequencer

This block sits on the controller side of a double-data-rate memory interface. It turns accepted write commands into a write burst on the strobe and data lanes. Each clock cycle it presents one word for the rising strobe edge and one word for the falling edge, with matching byte-mask bits. It also presents enables for the strobe and data drivers and the strobe level for that cycle. A physical double-rate output stage, which is not part of this block, takes these registered per-cycle values and serialises them.

Write commands arrive through a valid/ready handshake and carry a burst-length code. Write data arrives as whole rising/falling pairs through a second valid/ready handshake. The sequencer frames each burst with a low strobe cycle before the data (preamble) and a low strobe cycle after it (postamble). A new write can be accepted in any cycle. It either follows the earlier burst with no gap or cuts that burst short after exactly as many pairs as cycles have passed since the earlier write.

A read or precharge that interrupts a write is signalled on its own input. After a parameterised number of recovery cycles, the rest of the burst is still strobed, but with every mask bit set, so those words are never written. A data pair that is not available when the burst needs it is driven masked and flagged as an underrun.

Top module: `ddr_wr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, the strobe enable, strobe level, data enable, underrun flag, mask outputs and `wd_ready` are all low. From the second cycle after release, `cmd_ready` is high.
- R2: `cmd_blen` code 0 selects 2 pairs, code 1 selects 4 pairs and code 2 selects 8 pairs.
- R3: If no pair is being fetched when a write is accepted in cycle t, cycle t+1 drives the preamble: `dqs_oe`=1, `dqs_lvl`=0, `dq_oe`=0.
- R4: The pairs of a write accepted in cycle t are driven in consecutive cycles starting at t+2, with `dq_oe`=1 and `dqs_lvl`=1 (the strobe toggles). Words are driven in stream order. The mask comes from `wd_mask`: the low `MASK_W` bits go to `dm_rise` and the high bits go to `dm_fall`. A mask bit of 1 means the byte is not written.
- R5: The cycle after the last driven pair is a postamble (`dqs_oe`=1, `dqs_lvl`=0, `dq_oe`=0). When no new write follows, the next cycle has every enable low.
- R6: A write accepted in the cycle that fetches the last pair of the previous burst has its first pair driven in the very next data cycle, with no strobe gap.
- R7: A write accepted N cycles after the previous write, with N below that write's pair count, truncates the previous burst to its first N pairs.
- R8: A write accepted one cycle after the previous burst's last fetch produces a single low strobe cycle that serves as both postamble and preamble.
- R9: A read cut in cycle c during a burst keeps the pairs fetched in cycles c through c+RD_LAG. Every later pair of that burst is strobed with all mask bits set and zero data, and nothing is consumed from the data stream for those pairs.
- R10: A precharge cut behaves like R9, with PRE_LAG recovery cycles in place of RD_LAG.
- R11: A cut in the same cycle as an accepted write has no effect on the new burst, and a cut while no pair is being fetched has no effect.
- R12: If `wd_valid` is low in a fetch cycle of an unmasked pair, that pair is driven with all mask bits set and zero data, `underrun` is high in the cycle it is driven, and no data is consumed.
- R13: While no pair is being fetched, `wd_ready` is low and the data stream does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Write command can be taken |
| cmd_blen | input | 2 | Burst-length code (0:2, 1:4, 2:8 pairs) |
| rd_cut | input | 1 | Read interrupts the current write |
| pre_cut | input | 1 | Precharge interrupts the current write |
| wd_valid | input | 1 | Write data pair offered |
| wd_ready | output | 1 | Write data pair taken this cycle |
| wd_rise | input | DQ_W | Word for the rising strobe edge |
| wd_fall | input | DQ_W | Word for the falling strobe edge |
| wd_mask | input | 2*MASK_W | Byte masks, low half rising word, high half falling word |
| dqs_oe | output | 1 | Strobe driver enable |
| dqs_lvl | output | 1 | 1: strobe toggles this cycle, 0: strobe held low |
| dq_oe | output | 1 | Data driver enable |
| dq_rise | output | DQ_W | Rising-edge data word |
| dq_fall | output | DQ_W | Falling-edge data word |
| dm_rise | output | MASK_W | Rising-edge byte mask |
| dm_fall | output | MASK_W | Falling-edge byte mask |
| underrun | output | 1 | Pair driven masked because data was missing |

## Verification
Two of the block's functions can fall in the same cycle. The first is an interrupting cut arriving in the cycle a new write is accepted; the second is the postamble of one burst meeting the preamble of the next. The bench raises a read cut together with a truncating write and expects every pair of the new burst to go out unmasked, which would fail if the cut armed against the new burst. It also issues a write one cycle after a burst's last fetch and expects exactly one shared low strobe cycle before the new data, with no enable dropping in between.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

    localparam int MAX_PAIRS = 8;
    localparam int CNT_W     = $clog2(MAX_PAIRS + 1);

    typedef enum logic [1:0] {
        BLEN_2   = 2'd0,
        BLEN_4   = 2'd1,
        BLEN_8   = 2'd2,
        BLEN_RSV = 2'd3
    } blen_e;

    // Number of data pairs for a burst-length code; the reserved code runs a full burst.
    function automatic logic [CNT_W-1:0] pairs_of(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        case (blen_e'(code))
            BLEN_2:  n = CNT_W'(2);
            BLEN_4:  n = CNT_W'(4);
            default: n = CNT_W'(MAX_PAIRS);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ddr_wr_burst_ctr.sv
module ddr_wr_burst_ctr
    import ddr_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic [1:0] blen_i,
    output logic       fetch_o
);

    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.rem = pairs_of(blen_i);
        end else if (st_q.rem != '0) begin
            st_d.rem = st_q.rem - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_o = (st_q.rem != '0);

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rem <= CNT_W'(MAX_PAIRS)); // R2
    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> fetch_o); // R4

endmodule

// File: rtl/ddr_wr_cut_ctl.sv
module ddr_wr_cut_ctl #(
    parameter int RD_LAG  = 1,
    parameter int PRE_LAG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic fetch_i,
    input  logic rd_cut_i,
    input  logic pre_cut_i,
    output logic kill_o
);

    localparam int MAX_LAG = (RD_LAG > PRE_LAG) ? RD_LAG : PRE_LAG;
    localparam int LAG_W   = (MAX_LAG < 1) ? 1 : $clog2(MAX_LAG + 1);

    typedef struct packed {
        logic             arm;
        logic [LAG_W-1:0] lag;
    } cut_t;

    cut_t             st_d, st_q;
    logic [LAG_W-1:0] lag_pick;

    always_comb begin
        // With both cuts present, the shorter recovery window opens first.
        if (rd_cut_i && pre_cut_i) begin
            lag_pick = (RD_LAG < PRE_LAG) ? LAG_W'(RD_LAG) : LAG_W'(PRE_LAG);
        end else if (rd_cut_i) begin
            lag_pick = LAG_W'(RD_LAG);
        end else begin
            lag_pick = LAG_W'(PRE_LAG);
        end
    end

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d = '0;
        end else begin
            if (st_q.arm && st_q.lag != '0) begin
                st_d.lag = st_q.lag - LAG_W'(1);
            end
            if (!st_q.arm && fetch_i && (rd_cut_i || pre_cut_i)) begin
                st_d.arm = 1'b1;
                st_d.lag = lag_pick;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kill_o = st_q.arm && (st_q.lag == '0) && fetch_i;

    AST_CUT_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !kill_o); // R11
    AST_KILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_o && !accept_i) |=> (!fetch_i || kill_o)); // R9

endmodule

// File: rtl/ddr_wr_lane_drv.sv
module ddr_wr_lane_drv #(
    parameter int DQ_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept_i,
    input  logic                  fetch_i,
    input  logic                  kill_i,
    input  logic                  wd_valid_i,
    input  logic [DQ_W-1:0]       wd_rise_i,
    input  logic [DQ_W-1:0]       wd_fall_i,
    input  logic [2*(DQ_W/8)-1:0] wd_mask_i,
    output logic                  wd_ready_o,
    output logic                  dqs_oe_o,
    output logic                  dqs_lvl_o,
    output logic                  dq_oe_o,
    output logic [DQ_W-1:0]       dq_rise_o,
    output logic [DQ_W-1:0]       dq_fall_o,
    output logic [DQ_W/8-1:0]     dm_rise_o,
    output logic [DQ_W/8-1:0]     dm_fall_o,
    output logic                  underrun_o
);

    localparam int MASK_W = DQ_W / 8;

    typedef struct packed {
        logic              dqs_oe;
        logic              dqs_lvl;
        logic              dq_oe;
        logic              underrun;
        logic [MASK_W-1:0] dm_r;
        logic [MASK_W-1:0] dm_f;
        logic [DQ_W-1:0]   dq_r;
        logic [DQ_W-1:0]   dq_f;
    } lane_t;

    lane_t st_d, st_q;
    logic  take, short;

    assign take  = fetch_i && !kill_i && wd_valid_i;
    assign short = fetch_i && !kill_i && !wd_valid_i;

    always_comb begin
        st_d          = '0;
        st_d.dq_oe    = fetch_i;
        st_d.dqs_lvl  = fetch_i;
        st_d.dqs_oe   = fetch_i || accept_i || st_q.dq_oe;
        st_d.underrun = short;
        if (take) begin
            st_d.dq_r = wd_rise_i;
            st_d.dq_f = wd_fall_i;
            st_d.dm_r = wd_mask_i[MASK_W-1:0];
            st_d.dm_f = wd_mask_i[2*MASK_W-1:MASK_W];
        end else if (fetch_i) begin
            st_d.dm_r = '1;
            st_d.dm_f = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wd_ready_o = fetch_i && !kill_i;
    assign dqs_oe_o   = st_q.dqs_oe;
    assign dqs_lvl_o  = st_q.dqs_lvl;
    assign dq_oe_o    = st_q.dq_oe;
    assign dq_rise_o  = st_q.dq_r;
    assign dq_fall_o  = st_q.dq_f;
    assign dm_rise_o  = st_q.dm_r;
    assign dm_fall_o  = st_q.dm_f;
    assign underrun_o = st_q.underrun;

    AST_DQ_INSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dq_oe |-> st_q.dqs_oe); // R4
    AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !fetch_i) |=> (st_q.dqs_oe && !st_q.dq_oe)); // R3
    AST_POSTAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.dq_oe) |-> (st_q.dqs_oe && !st_q.dqs_lvl)); // R5
    AST_CUT_PAIR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (st_q.dq_oe && (&st_q.dm_r) && (&st_q.dm_f))); // R9
    AST_UNDERRUN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.underrun |-> ((&st_q.dm_r) && (&st_q.dm_f) && st_q.dq_oe)); // R12

endmodule

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq #(
    parameter int DQ_W    = 16,
    parameter int RD_LAG  = 1,
    parameter int PRE_LAG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [1:0]            cmd_blen,
    input  logic                  rd_cut,
    input  logic                  pre_cut,
    input  logic                  wd_valid,
    output logic                  wd_ready,
    input  logic [DQ_W-1:0]       wd_rise,
    input  logic [DQ_W-1:0]       wd_fall,
    input  logic [2*(DQ_W/8)-1:0] wd_mask,
    output logic                  dqs_oe,
    output logic                  dqs_lvl,
    output logic                  dq_oe,
    output logic [DQ_W-1:0]       dq_rise,
    output logic [DQ_W-1:0]       dq_fall,
    output logic [DQ_W/8-1:0]     dm_rise,
    output logic [DQ_W/8-1:0]     dm_fall,
    output logic                  underrun
);

    typedef struct packed {
        logic rdy;
    } top_t;

    top_t st_d, st_q;
    logic accept, fetch, kill;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready = st_q.rdy;
    assign accept    = cmd_valid && st_q.rdy;

    ddr_wr_burst_ctr u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .blen_i   (cmd_blen),
        .fetch_o  (fetch)
    );

    ddr_wr_cut_ctl #(
        .RD_LAG  (RD_LAG),
        .PRE_LAG (PRE_LAG)
    ) u_cut (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .fetch_i   (fetch),
        .rd_cut_i  (rd_cut),
        .pre_cut_i (pre_cut),
        .kill_o    (kill)
    );

    ddr_wr_lane_drv #(
        .DQ_W (DQ_W)
    ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .fetch_i    (fetch),
        .kill_i     (kill),
        .wd_valid_i (wd_valid),
        .wd_rise_i  (wd_rise),
        .wd_fall_i  (wd_fall),
        .wd_mask_i  (wd_mask),
        .wd_ready_o (wd_ready),
        .dqs_oe_o   (dqs_oe),
        .dqs_lvl_o  (dqs_lvl),
        .dq_oe_o    (dq_oe),
        .dq_rise_o  (dq_rise),
        .dq_fall_o  (dq_fall),
        .dm_rise_o  (dm_rise),
        .dm_fall_o  (dm_fall),
        .underrun_o (underrun)
    );

    AST_READY_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready |=> dq_oe); // R13

endmodule

// File: tb/ddr_wr_seq_tb_top.sv
module ddr_wr_seq_tb_top;

    localparam int DQ_W = 16;
    localparam int MW   = DQ_W / 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cmd_valid, cmd_ready;
    logic [1:0]      cmd_blen;
    logic            rd_cut, pre_cut;
    logic            wd_valid, wd_ready;
    logic [DQ_W-1:0] wd_rise, wd_fall;
    logic [2*MW-1:0] wd_mask;
    logic            dqs_oe, dqs_lvl, dq_oe, underrun;
    logic [DQ_W-1:0] dq_rise, dq_fall;
    logic [MW-1:0]   dm_rise, dm_fall;

    int checks = 0;
    int errors = 0;
    int tx_n   = 0;
    int exp_idx = 0;

    always #2 clk = ~clk;

    // Data source: pair n carries words 0x1000+2n / 0x1001+2n, rising mask n[1:0].
    always @(posedge clk) begin
        if (rst_n && wd_valid && wd_ready) tx_n <= tx_n + 1;
    end
    assign wd_rise = DQ_W'(32'h1000 + 2 * tx_n);
    assign wd_fall = DQ_W'(32'h1001 + 2 * tx_n);
    assign wd_mask = {MW'(0), MW'(tx_n)};

    ddr_wr_seq #(.DQ_W(DQ_W), .RD_LAG(1), .PRE_LAG(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_blen(cmd_blen), .rd_cut(rd_cut), .pre_cut(pre_cut),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_rise(wd_rise),
        .wd_fall(wd_fall), .wd_mask(wd_mask), .dqs_oe(dqs_oe),
        .dqs_lvl(dqs_lvl), .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dm_rise(dm_rise), .dm_fall(dm_fall), .underrun(underrun)
    );

    localparam int K_IDLE = 0, K_LOW = 1, K_DATA = 2, K_MASK = 3;

    // One cycle: move to the next falling edge, drop pulses, compare outputs.
    task automatic cyc(input string req, input int kind, input bit ur);
        logic [4+2*MW+2*DQ_W-1:0] got, exp;
        logic [MW-1:0]   e_dmr, e_dmf;
        logic [DQ_W-1:0] e_r, e_f;
        @(negedge clk);
        cmd_valid = 1'b0;
        rd_cut    = 1'b0;
        pre_cut   = 1'b0;
        wd_valid  = 1'b1;
        e_r = '0; e_f = '0; e_dmr = '0; e_dmf = '0;
        if (kind == K_DATA) begin
            e_r   = DQ_W'(32'h1000 + 2 * exp_idx);
            e_f   = DQ_W'(32'h1001 + 2 * exp_idx);
            e_dmr = MW'(exp_idx);
        end else if (kind == K_MASK) begin
            e_dmr = '1;
            e_dmf = '1;
        end
        exp = {kind != K_IDLE, kind >= K_DATA, kind >= K_DATA, ur, e_dmr, e_dmf, e_r, e_f};
        got = {dqs_oe, dqs_lvl, dq_oe, underrun, dm_rise, dm_fall, dq_rise, dq_fall};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0t got=%h exp=%h", req, $time, got, exp);
        end
        if (kind == K_DATA) exp_idx++;
    endtask

    task automatic issue(input logic [1:0] code);
        cmd_valid = 1'b1;
        cmd_blen  = code;
    endtask

    task automatic chk(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0t got=%0d exp=%0d", req, $time, act, expv);
        end
    endtask

    task automatic t_reset_idle();
        int snap;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_blen = 2'd0;
        rd_cut = 1'b0; pre_cut = 1'b0; wd_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 enables low in reset", !dqs_oe && !dq_oe && !dqs_lvl && !underrun, int'(dqs_oe), 0);
        chk("R1 ready low in reset", !wd_ready && dm_rise == '0, int'(wd_ready), 0);
        rst_n = 1'b1;
        cyc("R1 first cycle after reset", K_IDLE, 1'b0);
        chk("R1 cmd_ready high", cmd_ready === 1'b1, int'(cmd_ready), 1);
        snap = tx_n;
        cyc("R13 idle", K_IDLE, 1'b0);
        cyc("R13 idle", K_IDLE, 1'b0);
        chk("R13 wd_ready low when idle", wd_ready === 1'b0, int'(wd_ready), 0);
        chk("R13 stream not consumed when idle", tx_n == snap, tx_n, snap);
    endtask

    task automatic t_single_bl4();
        issue(2'd1);
        cyc("R3 preamble", K_LOW, 1'b0);
        repeat (4) cyc("R4 R2 bl4 data", K_DATA, 1'b0);
        cyc("R5 postamble", K_LOW, 1'b0);
        cyc("R5 idle after postamble", K_IDLE, 1'b0);
    endtask

    task automatic t_single_bl8();
        issue(2'd2);
        cyc("R3 preamble", K_LOW, 1'b0);
        repeat (8) cyc("R2 bl8 data", K_DATA, 1'b0);
        cyc("R5 postamble", K_LOW, 1'b0);
        cyc("R5 idle", K_IDLE, 1'b0);
    endtask

    task automatic t_concat();
        issue(2'd1);
        cyc("R3 preamble", K_LOW, 1'b0);
        repeat (3) cyc("R6 first burst", K_DATA, 1'b0);
        issue(2'd0);
        cyc("R6 first burst last", K_DATA, 1'b0);
        repeat (2) cyc("R6 R2 bl2 joined", K_DATA, 1'b0);
        cyc("R6 postamble", K_LOW, 1'b0);
        cyc("R6 idle", K_IDLE, 1'b0);
    endtask

    task automatic t_truncate();
        issue(2'd2);
        cyc("R3 preamble", K_LOW, 1'b0);
        cyc("R7 kept pair", K_DATA, 1'b0);
        issue(2'd1);
        cyc("R7 kept pair", K_DATA, 1'b0);
        repeat (4) cyc("R7 new burst", K_DATA, 1'b0);
        cyc("R7 postamble", K_LOW, 1'b0);
        cyc("R7 idle", K_IDLE, 1'b0);
    endtask

    task automatic t_gap_one();
        issue(2'd0);
        cyc("R3 preamble", K_LOW, 1'b0);
        repeat (2) cyc("R8 first burst", K_DATA, 1'b0);
        issue(2'd0);
        cyc("R8 shared low cycle", K_LOW, 1'b0);
        repeat (2) cyc("R8 second burst", K_DATA, 1'b0);
        cyc("R8 postamble", K_LOW, 1'b0);
        cyc("R8 idle", K_IDLE, 1'b0);
    endtask

    task automatic t_read_cut();
        issue(2'd2);
        cyc("R3 preamble", K_LOW, 1'b0);
        cyc("R9 kept", K_DATA, 1'b0);
        rd_cut = 1'b1;
        repeat (2) cyc("R9 kept in window", K_DATA, 1'b0);
        repeat (5) cyc("R9 masked after read", K_MASK, 1'b0);
        cyc("R9 postamble", K_LOW, 1'b0);
        cyc("R9 idle", K_IDLE, 1'b0);
    endtask

    task automatic t_pre_cut();
        issue(2'd1);
        cyc("R3 preamble", K_LOW, 1'b0);
        pre_cut = 1'b1;
        repeat (3) cyc("R10 kept in window", K_DATA, 1'b0);
        cyc("R10 masked after precharge", K_MASK, 1'b0);
        cyc("R10 postamble", K_LOW, 1'b0);
        cyc("R10 idle", K_IDLE, 1'b0);
    endtask

    task automatic t_cut_with_write();
        issue(2'd1);
        cyc("R3 preamble", K_LOW, 1'b0);
        cyc("R11 first burst", K_DATA, 1'b0);
        issue(2'd0);
        rd_cut = 1'b1;
        cyc("R11 first burst kept", K_DATA, 1'b0);
        repeat (2) cyc("R11 new burst unmasked", K_DATA, 1'b0);
        cyc("R11 postamble", K_LOW, 1'b0);
        rd_cut = 1'b1;
        pre_cut = 1'b1;
        cyc("R11 idle cut", K_IDLE, 1'b0);
        issue(2'd0);
        cyc("R11 preamble after idle cut", K_LOW, 1'b0);
        repeat (2) cyc("R11 burst after idle cut", K_DATA, 1'b0);
        cyc("R11 postamble", K_LOW, 1'b0);
        cyc("R11 idle", K_IDLE, 1'b0);
    endtask

    task automatic t_underrun();
        issue(2'd1);
        cyc("R3 preamble", K_LOW, 1'b0);
        wd_valid = 1'b0;
        cyc("R12 underrun pair", K_MASK, 1'b1);
        repeat (3) cyc("R12 data after underrun", K_DATA, 1'b0);
        cyc("R12 postamble", K_LOW, 1'b0);
        cyc("R12 idle", K_IDLE, 1'b0);
    endtask

    initial begin
        t_reset_idle();
        t_single_bl4();
        t_single_bl8();
        t_concat();
        t_truncate();
        t_gap_one();
        t_read_cut();
        t_pre_cut();
        t_cut_with_write();
        t_underrun();
        chk("R13 stream position", tx_n == exp_idx, tx_n, exp_idx);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired, all requirements unfinished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule